// File: doc/BRIEF.md
# Interrupt Aggregation Controller

This block gathers single-cycle event pulses from ten internal sources into a register of sticky flags. A companion register holds one enable bit per source and a global enable bit. When the global enable is on and at least one flag is set with its enable bit, the block drives a single active-low interrupt line low. A status register mirrors that condition so that a host without the pin wired can poll for it. Flags latch whether or not their source is enabled, so low-priority events can be polled while only the important ones reach the pin.

The host reaches the registers through a small port with an address, a 16-bit write bus, an operation select and a combinational read bus. Besides a plain write, the port offers bit-set and bit-clear operations, so the host can clear flags without a read-modify-write. Clearing and restoring the global enable bit makes the pin rise and then fall again, which gives an edge-triggered host a new edge for any events still pending. An event that lands in the same cycle as a clear or write of its flag still leaves the flag set.

Top module: `irq_merge_ctl`

## Requirements
- R1: A pulse on `evt_i[k]` sets flag bit k (flags register, address 0, bits 0..9) on that clock edge, whatever the value of enable bit k or of the global enable.
- R2: A set flag stays set until the host clears it with a plain write or a bit-clear operation on address 0.
- R3: One clock after the global enable (address 1, bit 15) and some flag with its enable bit (address 1, bits 0..9) are both set, `irq_n_o` goes low, and bit 15 of the status register (address 2) reads 1 for as long as the pin is low.
- R4: The pin stays low until every flag that is set with its enable bit has been cleared or has had its enable bit cleared. It returns high one clock after the last one is removed.
- R5: Clearing the global enable drives the pin high one clock later. Setting it again while an enabled flag is pending drives the pin low one clock later, which gives the host a new falling edge.
- R6: Operation select `op_i` encodes 2'b00 read, 2'b01 plain write, 2'b10 bit-set (OR with write data) and 2'b11 bit-clear (AND with inverted write data). Write, set and clear act on address 0 (flags) and address 1 (enables).
- R7: If an event and a bit-clear or plain write that would clear the same flag come in one cycle, the flag ends up set.
- R8: During a read, unused bits read zero: flags bits 15..10, enables bits 14..10, status bits 14..0, and all of address 3. Writes to addresses 2 and 3 have no effect. When `op_i` is not read, `rdata_o` is zero.
- R9: After reset, all flags and enables are clear, the pin is high and the status register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 10 | Single-cycle event pulses, one per source |
| addr_i | input | 2 | Register address: 0 flags, 1 enables, 2 status |
| op_i | input | 2 | Operation: read, write, set, clear |
| wdata_i | input | 16 | Write data or bit mask |
| rdata_o | output | 16 | Read data for the addressed register |
| irq_n_o | output | 1 | Active-low interrupt output |

## Verification
The bench drives an event in the same cycle as a bit-clear of its flag, and in the same cycle as a plain write of zero. A design that lets the host operation win would lose that event without any trace. It cycles the global enable with a flag still pending and checks that the pin rises and then falls again. A design that gated only the rising side, or did not re-evaluate, would give no second edge. It keeps two enabled flags pending and removes them one at a time, once by clearing the flag and once by clearing the enable, to catch a pin that is released too early. It also checks that a disabled source still latches its flag while the pin stays high, and checks the sample points at which the registered pin must and must not have moved.

// File: rtl/irq_merge_ctl.sv
module irq_merge_ctl #(
  parameter int NUM_SRC = 10,
  parameter int DW      = 16,
  parameter int AW      = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [1:0]         op_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  output logic               irq_n_o
);
  localparam int GIE_BIT = DW - 1;
  localparam logic [1:0] OP_RD  = 2'b00;
  localparam logic [1:0] OP_WR  = 2'b01;
  localparam logic [1:0] OP_SET = 2'b10;
  localparam logic [1:0] OP_CLR = 2'b11;
  localparam logic [AW-1:0] A_FLAG = AW'(0);
  localparam logic [AW-1:0] A_EN   = AW'(1);
  localparam logic [AW-1:0] A_STAT = AW'(2);

  logic [NUM_SRC-1:0] flags, flags_n;
  logic [NUM_SRC-1:0] en, en_n;
  logic               gie, gie_n;
  logic               irq_q;

  wire [NUM_SRC-1:0] wsrc = wdata_i[NUM_SRC-1:0];
  wire               wgie = wdata_i[GIE_BIT];
  wire               hit_flag = (addr_i == A_FLAG);
  wire               hit_en   = (addr_i == A_EN);

  always_comb begin
    flags_n = flags;
    if (hit_flag) begin
      case (op_i)
        OP_WR:   flags_n = wsrc;
        OP_SET:  flags_n = flags | wsrc;
        OP_CLR:  flags_n = flags & ~wsrc;
        default: flags_n = flags;
      endcase
    end
    flags_n = flags_n | evt_i;
  end

  always_comb begin
    en_n  = en;
    gie_n = gie;
    if (hit_en) begin
      case (op_i)
        OP_WR:   begin en_n = wsrc;        gie_n = wgie;        end
        OP_SET:  begin en_n = en | wsrc;   gie_n = gie | wgie;  end
        OP_CLR:  begin en_n = en & ~wsrc;  gie_n = gie & ~wgie; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      en    <= '0;
      gie   <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      flags <= flags_n;
      en    <= en_n;
      gie   <= gie_n;
      irq_q <= gie & |(flags & en);
    end
  end

  assign irq_n_o = ~irq_q;

  always_comb begin
    rdata_o = '0;
    if (op_i == OP_RD) begin
      case (addr_i)
        A_FLAG: rdata_o[NUM_SRC-1:0] = flags;
        A_EN: begin
          rdata_o[NUM_SRC-1:0] = en;
          rdata_o[GIE_BIT]     = gie;
        end
        A_STAT: rdata_o[GIE_BIT] = irq_q;
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

module irq_merge_ctl_chk #(
  parameter int NUM_SRC = 10,
  parameter int DW      = 16,
  parameter int AW      = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] evt_i,
  input logic [AW-1:0]      addr_i,
  input logic [1:0]         op_i,
  input logic [DW-1:0]      rdata_o,
  input logic               irq_n_o,
  input logic [NUM_SRC-1:0] flags,
  input logic [NUM_SRC-1:0] en,
  input logic               gie
);
  wire host_clears = (addr_i == AW'(0)) && (op_i == 2'b01 || op_i == 2'b11);

  p_event_latch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((flags & $past(evt_i)) == $past(evt_i)));

  p_flag_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !host_clears |=> ((flags & $past(flags)) == $past(flags)));

  p_pending_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gie && |(flags & en)) |=> !irq_n_o);

  p_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(flags & en)) |=> irq_n_o);

  p_gie_off_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |=> irq_n_o);

  p_unused_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 2'b00 && addr_i == AW'(0)) |-> ((rdata_o >> NUM_SRC) == '0));
endmodule

bind irq_merge_ctl irq_merge_ctl_chk #(.NUM_SRC(NUM_SRC), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .addr_i(addr_i), .op_i(op_i),
  .rdata_o(rdata_o), .irq_n_o(irq_n_o), .flags(flags), .en(en), .gie(gie));

// File: tb/irq_merge_ctl_test.sv
module irq_merge_ctl_test;
  localparam int PERIOD = 10;
  localparam logic [1:0] RD = 2'b00, WR = 2'b01, ST = 2'b10, CL = 2'b11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  evt = '0;
  logic [1:0]  addr = '0;
  logic [1:0]  op = RD;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq_n;
  int vectors = 0;
  int fails = 0;

  irq_merge_ctl uut (.clk(clk), .rst_n(rst_n), .evt_i(evt), .addr_i(addr), .op_i(op),
                     .wdata_i(wdata), .rdata_o(rdata), .irq_n_o(irq_n));

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [1:0] a, input logic [1:0] o, input logic [15:0] d,
                     input logic [9:0] e);
    addr = a; op = o; wdata = d; evt = e;
    @(posedge clk);
    @(negedge clk);
    op = RD; evt = '0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    addr = a; op = RD;
    #1 v = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(2'd0, RD, 16'h0, 10'h0);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    check("R9 pin", {15'h0, irq_n}, 16'h1);
    rd(2'd0, v); check("R9 flags", v, 16'h0);
    rd(2'd1, v); check("R9 enables", v, 16'h0);
    rd(2'd2, v); check("R9 status", v, 16'h0);
  endtask

  task automatic t_poll;
    logic [15:0] v;
    cyc(2'd0, RD, 16'h0, 10'h008);
    rd(2'd0, v); check("R1 disabled flag latches", v, 16'h0008);
    cyc(2'd1, ST, 16'h8000, 10'h0);
    idle(2);
    check("R1 pin high when source disabled", {15'h0, irq_n}, 16'h1);
    idle(5);
    rd(2'd0, v); check("R2 flag sticky", v, 16'h0008);
  endtask

  task automatic t_assert;
    logic [15:0] v;
    cyc(2'd1, ST, 16'h0008, 10'h0);
    check("R3 pin not yet low", {15'h0, irq_n}, 16'h1);
    idle(1);
    check("R3 pin low one clock later", {15'h0, irq_n}, 16'h0);
    rd(2'd2, v); check("R3 status mirror", v, 16'h8000);
  endtask

  task automatic t_hold;
    logic [15:0] v;
    cyc(2'd1, ST, 16'h0020, 10'h020);
    cyc(2'd0, CL, 16'h0008, 10'h0);
    idle(2);
    check("R4 pin held by other flag", {15'h0, irq_n}, 16'h0);
    cyc(2'd1, CL, 16'h0020, 10'h0);
    idle(1);
    check("R4 pin high after mask", {15'h0, irq_n}, 16'h1);
    rd(2'd0, v); check("R4 masked flag still set", v, 16'h0020);
  endtask

  task automatic t_gie;
    cyc(2'd1, ST, 16'h0020, 10'h0);
    idle(1);
    check("R5 pin low pending", {15'h0, irq_n}, 16'h0);
    cyc(2'd1, CL, 16'h8000, 10'h0);
    idle(1);
    check("R5 pin high after global off", {15'h0, irq_n}, 16'h1);
    cyc(2'd1, ST, 16'h8000, 10'h0);
    check("R5 pin still high same clock", {15'h0, irq_n}, 16'h1);
    idle(1);
    check("R5 new falling edge", {15'h0, irq_n}, 16'h0);
  endtask

  task automatic t_race;
    logic [15:0] v;
    cyc(2'd0, CL, 16'h0020, 10'h020);
    rd(2'd0, v); check("R7 event beats clear", v, 16'h0020);
    cyc(2'd0, WR, 16'h0000, 10'h004);
    rd(2'd0, v); check("R7 event beats write", v, 16'h0004);
    cyc(2'd0, CL, 16'h0004, 10'h0);
    rd(2'd0, v); check("R2 clear removes flag", v, 16'h0000);
    idle(1);
    check("R4 pin high after clear", {15'h0, irq_n}, 16'h1);
  endtask

  task automatic t_ops;
    logic [15:0] v;
    cyc(2'd1, WR, 16'h00FF, 10'h0);
    rd(2'd1, v); check("R6 enable write", v, 16'h00FF);
    cyc(2'd1, ST, 16'h0300, 10'h0);
    rd(2'd1, v); check("R6 enable set", v, 16'h03FF);
    cyc(2'd1, CL, 16'h000F, 10'h0);
    rd(2'd1, v); check("R6 enable clear", v, 16'h03F0);
    cyc(2'd1, WR, 16'hFFFF, 10'h0);
    rd(2'd1, v); check("R8 enable unused zero", v, 16'h83FF);
    cyc(2'd0, ST, 16'hFC01, 10'h0);
    rd(2'd0, v); check("R6 flag set op, R8 unused zero", v, 16'h0001);
    idle(1);
    rd(2'd2, v); check("R3 status on", v, 16'h8000);
    cyc(2'd2, WR, 16'h0000, 10'h0);
    cyc(2'd3, WR, 16'hFFFF, 10'h0);
    rd(2'd2, v); check("R8 status write ignored", v, 16'h8000);
    rd(2'd3, v); check("R8 unmapped reads zero", v, 16'h0000);
    rd(2'd1, v); check("R8 enables untouched", v, 16'h83FF);
    addr = 2'd1; op = WR; #1;
    check("R8 no read data outside read", rdata, 16'h0000);
    op = RD;
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_poll();
    t_assert();
    t_hold();
    t_gie();
    t_race();
    t_ops();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule